// File: doc/BRIEF.md
# Dual-Channel DAC Sample Buffer Controller

This block is the digital front end of a two-channel digital-to-analog converter. Each channel keeps a 12-bit live sample that feeds the converter and a 12-bit staging buffer that software fills ahead of time. A bus write to a channel's live-sample register starts a conversion at once. When event loading is enabled, an edge on the channel's trigger input moves the staged value into the live register and starts a conversion. This gives conversions a fixed rate set by an external timer.

Each channel's buffer is tracked by a two-state machine. In `BUF_EMPTY` a buffer write takes the FILL transition to `BUF_FULL`, and a trigger event takes the STARVE self-loop, which raises the underrun flag. In `BUF_FULL` a trigger event takes DRAIN back to `BUF_EMPTY`. If a buffer write arrives in the same cycle as that event, the machine takes the DRAIN_REFILL self-loop and stays in `BUF_FULL`. A buffer write while full takes the RELOAD self-loop. Each channel's samples can be placed at either end of the 16-bit register. In differential mode channel 1 runs in lockstep with channel 0.

Top module: `dacbuf_ctrl`

## Requirements
- R1: After reset, every output is 0, every register reads 0 and both buffers are empty. The map is: address 0 configuration, 1 status, 2 and 3 live sample of channel 0 and 1, 4 and 5 buffer of channel 0 and 1; other addresses read 0 and writes to them are dropped. Configuration bits: 0 differential, 1+c left adjust, 3+c event loading, 5+c falling-edge trigger, 7+c buffer-empty event output enable, for channel c.
- R2: A bus write to a live-sample register makes `conv_start` of that channel 1 for exactly the next cycle, with `conv_sample` showing the written sample.
- R3: With event loading on and the buffer full, a trigger event copies the buffer to the live sample, strobes `conv_start` the next cycle and leaves the buffer empty.
- R4: Each event-driven transfer sets the channel's empty flag: status bit 0 for channel 0, bit 1 for channel 1.
- R5: A trigger event while the buffer is empty sets the underrun flag (status bit 2 for channel 0, bit 3 for channel 1). It gives no strobe and leaves the live sample unchanged.
- R6: Writing 1 to a status bit clears that bit and writing 0 leaves it alone. A set and a clear in the same cycle leave the bit set.
- R7: When enabled, `empty_evt` of a channel pulses for one cycle with each event-driven transfer. When disabled, it stays 0.
- R8: A trigger event is a 0-to-1 change of `trig_in`, or a 1-to-0 change when the falling-edge bit is set.
- R9: A right-adjusted channel takes and returns its sample in bits 11:0. A left-adjusted channel uses bits 15:4. The unused bits always read 0.
- R10: In differential mode any channel-0 start strobes both channels. Channel 1 trigger events are ignored, and channel 1 bus writes update its sample without a strobe.
- R11: When a trigger event and a buffer write hit one channel in the same cycle, the event takes the old buffer value and the buffer stays full with the new value.
- R12: With event loading off, trigger edges change no flag, sample or strobe.
- R13: When a trigger transfer and a live-sample bus write hit one channel in the same cycle, the transferred buffer value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write address |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 16 | Read data, combinational from state |
| trig_in | input | 2 | Per-channel trigger level |
| conv_start | output | 2 | Per-channel one-cycle conversion strobe |
| conv_sample | output | 24 | Per-channel 12-bit live sample, channel 0 in low bits |
| empty_evt | output | 2 | Per-channel buffer-empty event pulse |

## Verification
The bench builds the block with its defaults: two channels, 12-bit samples, 16-bit registers and a 3-bit address. Two channels make the differential pairing reachable. The 3-bit address leaves addresses 6 and 7 unmapped, so the bench also exercises dropped writes and zero reads. A long random phase writes the configuration with random values, so edge polarity, adjustment and differential mode flip in the middle of traffic. This brings same-cycle collisions and spurious edges from polarity changes within reach of the reference model.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_FULL  = 1'b1
    } buf_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_STAT,
        SEL_DATA,
        SEL_BUF
    } reg_sel_e;

endpackage

// File: rtl/dacbuf_edge.sv
module dacbuf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic falling,
    output logic hit
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    always_comb begin
        if (falling) hit = prev_q & ~sig;
        else         hit = ~prev_q & sig;
    end

endmodule

// File: rtl/dacbuf_decode.sv
module dacbuf_decode
    import dacbuf_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 3,
    parameter int IDX_W  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);

    localparam int unsigned DATA_BASE = 2;
    localparam int unsigned BUF_BASE  = 2 + NCH;
    localparam int unsigned MAP_END   = 2 + 2 * NCH;

    int unsigned a;

    always_comb begin
        a   = {{(32-ADDR_W){1'b0}}, addr};
        sel = SEL_NONE;
        idx = '0;
        if (a == 0) begin
            sel = SEL_CFG;
        end else if (a == 1) begin
            sel = SEL_STAT;
        end else if (a < BUF_BASE) begin
            sel = SEL_DATA;
            idx = IDX_W'(a - DATA_BASE);
        end else if (a < MAP_END) begin
            sel = SEL_BUF;
            idx = IDX_W'(a - BUF_BASE);
        end
    end

endmodule

// File: rtl/dacbuf_chan.sv
module dacbuf_chan
    import dacbuf_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int REG_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                left_adj,
    input  logic                ev_en,
    input  logic                ev_out_en,
    input  logic                follow,
    input  logic                trig_hit,
    input  logic                wr_data,
    input  logic                wr_buf,
    input  logic [REG_W-1:0]    wdata,
    input  logic                clr_empty,
    input  logic                clr_under,
    output logic                start_q,
    output logic [SAMPLE_W-1:0] sample_q,
    output logic [REG_W-1:0]    data_view,
    output logic [REG_W-1:0]    buf_view,
    output logic                flag_empty,
    output logic                flag_under,
    output logic                empty_pulse
);

    localparam int PAD_W = REG_W - SAMPLE_W;

    buf_state_e          state_q, state_d;
    logic                ev, xfer, urun;
    logic [SAMPLE_W-1:0] wr_sample, buf_q;

    always_comb begin
        ev        = trig_hit & ev_en & ~follow;
        xfer      = ev && (state_q == BUF_FULL);
        urun      = ev && (state_q == BUF_EMPTY);
        wr_sample = left_adj ? wdata[REG_W-1 -: SAMPLE_W] : wdata[SAMPLE_W-1:0];
        data_view = left_adj ? {sample_q, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, sample_q};
        buf_view  = left_adj ? {buf_q, {PAD_W{1'b0}}}    : {{PAD_W{1'b0}}, buf_q};
    end

    // FILL, RELOAD, DRAIN, DRAIN_REFILL, STARVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (wr_buf) state_d = BUF_FULL;
            BUF_FULL:  if (xfer && !wr_buf) state_d = BUF_EMPTY;
            default:   state_d = BUF_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q     <= 1'b0;
            empty_pulse <= 1'b0;
            sample_q    <= '0;
            buf_q       <= '0;
            flag_empty  <= 1'b0;
            flag_under  <= 1'b0;
        end else begin
            start_q     <= xfer | wr_data;
            empty_pulse <= xfer & ev_out_en;
            if (xfer)         sample_q <= buf_q;
            else if (wr_data) sample_q <= wr_sample;
            if (wr_buf) buf_q <= wr_sample;
            if (xfer)           flag_empty <= 1'b1;
            else if (clr_empty) flag_empty <= 1'b0;
            if (urun)           flag_under <= 1'b1;
            else if (clr_under) flag_under <= 1'b0;
        end
    end

    a_r2_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> start_q);

    a_r3_event_loads: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (sample_q == $past(buf_q)) && start_q && flag_empty);

    a_r5_underrun_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (urun && !wr_data) |=> flag_under && !start_q && $stable(sample_q));

    a_r11_refill_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && wr_buf) |=> (state_q == BUF_FULL) && (buf_q == $past(wr_sample)));

    a_r7_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        empty_pulse |-> flag_empty);

endmodule

// File: rtl/dacbuf_ctrl.sv
module dacbuf_ctrl
    import dacbuf_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int SAMPLE_W = 12,
    parameter int REG_W    = 16,
    parameter int ADDR_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_waddr,
    input  logic [REG_W-1:0]        bus_wdata,
    input  logic [ADDR_W-1:0]       bus_raddr,
    output logic [REG_W-1:0]        bus_rdata,
    input  logic [NCH-1:0]          trig_in,
    output logic [NCH-1:0]          conv_start,
    output logic [NCH*SAMPLE_W-1:0] conv_sample,
    output logic [NCH-1:0]          empty_evt
);

    localparam int CFG_W  = 1 + 4 * NCH;
    localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PAD_W  = REG_W - SAMPLE_W;
    localparam int F_LEFT = 1;
    localparam int F_SOE  = 1 + NCH;
    localparam int F_FALL = 1 + 2 * NCH;
    localparam int F_EVT  = 1 + 3 * NCH;

    logic [CFG_W-1:0]    cfg_q;
    reg_sel_e            wsel, rsel;
    logic [IDX_W-1:0]    widx, ridx;
    logic [NCH-1:0]      start_q, flag_e, flag_u, hit;
    logic [REG_W-1:0]    data_view [NCH];
    logic [REG_W-1:0]    buf_view  [NCH];
    logic [SAMPLE_W-1:0] sample    [NCH];

    dacbuf_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wdec (
        .addr(bus_waddr), .sel(wsel), .idx(widx)
    );

    dacbuf_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rdec (
        .addr(bus_raddr), .sel(rsel), .idx(ridx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                          cfg_q <= '0;
        else if (bus_we && wsel == SEL_CFG)  cfg_q <= bus_wdata[CFG_W-1:0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam bit PARTNER = (g == 1);
        logic follow, wr_d, wr_b, clr_e, clr_u;

        assign follow = PARTNER && cfg_q[0];
        assign wr_d   = bus_we && (wsel == SEL_DATA) && (widx == IDX_W'(g));
        assign wr_b   = bus_we && (wsel == SEL_BUF)  && (widx == IDX_W'(g));
        assign clr_e  = bus_we && (wsel == SEL_STAT) && bus_wdata[g];
        assign clr_u  = bus_we && (wsel == SEL_STAT) && bus_wdata[NCH+g];

        dacbuf_edge u_edge (
            .clk(clk), .rst_n(rst_n), .sig(trig_in[g]),
            .falling(cfg_q[F_FALL+g]), .hit(hit[g])
        );

        dacbuf_chan #(.SAMPLE_W(SAMPLE_W), .REG_W(REG_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .left_adj(cfg_q[F_LEFT+g]), .ev_en(cfg_q[F_SOE+g]),
            .ev_out_en(cfg_q[F_EVT+g]), .follow(follow),
            .trig_hit(hit[g]), .wr_data(wr_d), .wr_buf(wr_b),
            .wdata(bus_wdata), .clr_empty(clr_e), .clr_under(clr_u),
            .start_q(start_q[g]), .sample_q(sample[g]),
            .data_view(data_view[g]), .buf_view(buf_view[g]),
            .flag_empty(flag_e[g]), .flag_under(flag_u[g]),
            .empty_pulse(empty_evt[g])
        );

        assign conv_start[g] = follow ? start_q[0] : start_q[g];
        assign conv_sample[g*SAMPLE_W +: SAMPLE_W] = sample[g];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (rsel)
            SEL_CFG:  bus_rdata = REG_W'(cfg_q);
            SEL_STAT: bus_rdata = REG_W'({flag_u, flag_e});
            SEL_DATA: bus_rdata = data_view[ridx];
            SEL_BUF:  bus_rdata = buf_view[ridx];
            default:  bus_rdata = '0;
        endcase
    end

    a_r9_pad_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == SEL_DATA && cfg_q[F_LEFT + int'(ridx)]) |-> (bus_rdata[PAD_W-1:0] == '0));

    a_r1_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == SEL_NONE) |-> (bus_rdata == '0));

    if (NCH > 1) begin : g_pair
        a_r10_partner_ignores_trigger: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[0] && hit[1] && !(bus_we && wsel == SEL_STAT))
            |=> (flag_u[1] == $past(flag_u[1])) && (flag_e[1] == $past(flag_e[1])));
    end

endmodule

// File: tb/dacbuf_ctrl_bench.sv
`timescale 1ns/1ps
module dacbuf_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_waddr = '0;
    logic [15:0] bus_wdata = '0;
    logic [2:0]  bus_raddr = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  trig_in = '0;
    logic [1:0]  conv_start;
    logic [23:0] conv_sample;
    logic [1:0]  empty_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dacbuf_ctrl u_dacbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .conv_start(conv_start), .conv_sample(conv_sample),
        .empty_evt(empty_evt)
    );

    // behavioural reference model
    logic [8:0]  mcfg;
    logic [11:0] mdata [2];
    logic [11:0] mbuf  [2];
    bit mfull [2], mfe [2], mfu [2], mprev [2], mstart [2], mevt [2];

    function automatic logic [11:0] ext(logic [15:0] w, bit left);
        return left ? w[15:4] : w[11:0];
    endfunction

    function automatic logic [15:0] fmt(logic [11:0] s, bit left);
        return left ? {s, 4'h0} : {4'h0, s};
    endfunction

    function automatic logic [15:0] mread(logic [2:0] a);
        case (a)
            3'd0: return {7'd0, mcfg};
            3'd1: return {12'd0, mfu[1], mfu[0], mfe[1], mfe[0]};
            3'd2: return fmt(mdata[0], mcfg[1]);
            3'd3: return fmt(mdata[1], mcfg[2]);
            3'd4: return fmt(mbuf[0], mcfg[1]);
            3'd5: return fmt(mbuf[1], mcfg[2]);
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mcfg = '0;
            for (int c = 0; c < 2; c++) begin
                mdata[c] = '0; mbuf[c] = '0; mfull[c] = 0; mfe[c] = 0;
                mfu[c] = 0; mprev[c] = 0; mstart[c] = 0; mevt[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit fol, edg, ev, xf, ur, wb, wd, ce, cu, lft;
                fol = (c == 1) && mcfg[0];
                lft = mcfg[1+c];
                edg = mcfg[5+c] ? (mprev[c] && !trig_in[c]) : (!mprev[c] && trig_in[c]);
                ev  = edg && mcfg[3+c] && !fol;
                xf  = ev && mfull[c];
                ur  = ev && !mfull[c];
                wd  = bus_we && bus_waddr == 3'(2 + c);
                wb  = bus_we && bus_waddr == 3'(4 + c);
                ce  = bus_we && bus_waddr == 3'd1 && bus_wdata[c];
                cu  = bus_we && bus_waddr == 3'd1 && bus_wdata[2+c];
                mstart[c] = xf || wd;
                mevt[c]   = xf && mcfg[7+c];
                if (xf)      mdata[c] = mbuf[c];
                else if (wd) mdata[c] = ext(bus_wdata, lft);
                if (wb)      mbuf[c] = ext(bus_wdata, lft);
                if (wb)      mfull[c] = 1;
                else if (xf) mfull[c] = 0;
                if (xf)      mfe[c] = 1;
                else if (ce) mfe[c] = 0;
                if (ur)      mfu[c] = 1;
                else if (cu) mfu[c] = 0;
                mprev[c] = trig_in[c];
            end
            if (bus_we && bus_waddr == 3'd0) mcfg = bus_wdata[8:0];
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 2; c++) begin
                bit es;
                es = (c == 1 && mcfg[0]) ? mstart[0] : mstart[c];
                chk("R2 conv_start", int'(conv_start[c]), int'(es));
                chk("R3 conv_sample", int'(conv_sample[c*12 +: 12]), int'(mdata[c]));
                chk("R7 empty_evt", int'(empty_evt[c]), int'(mevt[c]));
            end
            chk("R9 bus_rdata", int'(bus_rdata), int'(mread(bus_raddr)));
        end
    end

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic step_trig(int c, bit v);
        @(negedge clk); #1;
        trig_in[c] = v;
        @(negedge clk); #1;
    endtask

    task automatic rd(logic [2:0] a, logic [15:0] exp, string tag);
        bus_raddr = a; #1;
        chk(tag, int'(bus_rdata), int'(exp));
    endtask

    function automatic logic [11:0] smp(int c);
        return conv_sample[c*12 +: 12];
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 conv_start", int'(conv_start), 0);
        chk("R1 empty_evt", int'(empty_evt), 0);
        chk("R1 conv_sample", int'(conv_sample), 0);
        rd(3'd1, 16'h0, "R1 status");
        rd(3'd4, 16'h0, "R1 buffer");

        wr(3'd0, 16'h0198);          // event loading and empty events on, right adjust
        rd(3'd0, 16'h0198, "R1 config readback");
        wr(3'd2, 16'h0ABC);
        chk("R2 strobe", int'(conv_start), 1);
        chk("R2 sample", int'(smp(0)), 'hABC);

        step_trig(0, 1'b1);          // buffer empty
        chk("R5 no strobe", int'(conv_start), 0);
        chk("R5 sample kept", int'(smp(0)), 'hABC);
        rd(3'd1, 16'h0004, "R5 underrun flag");
        step_trig(0, 1'b0);

        wr(3'd4, 16'h0123);
        step_trig(0, 1'b1);
        chk("R3 strobe", int'(conv_start), 1);
        chk("R3 sample", int'(smp(0)), 'h123);
        chk("R7 pulse", int'(empty_evt), 1);
        rd(3'd1, 16'h0005, "R4 empty flag");
        step_trig(0, 1'b0);
        chk("R7 single pulse", int'(empty_evt), 0);

        wr(3'd1, 16'h0005);
        rd(3'd1, 16'h0000, "R6 write-one clear");

        wr(3'd0, 16'h0190);          // event loading off on channel 0
        wr(3'd4, 16'h0777);
        step_trig(0, 1'b1);
        chk("R12 no strobe", int'(conv_start), 0);
        chk("R12 sample kept", int'(smp(0)), 'h123);
        rd(3'd1, 16'h0000, "R12 no flags");
        step_trig(0, 1'b0);
        wr(3'd0, 16'h0198);

        // R11 buffer write and event in one cycle
        @(negedge clk); #1;
        bus_we = 1'b1; bus_waddr = 3'd4; bus_wdata = 16'h0456; trig_in[0] = 1'b1;
        @(negedge clk); #1;
        bus_we = 1'b0;
        chk("R11 old value taken", int'(smp(0)), 'h777);
        rd(3'd4, 16'h0456, "R11 new buffer value");
        step_trig(0, 1'b0);
        step_trig(0, 1'b1);
        chk("R11 buffer still full", int'(smp(0)), 'h456);
        chk("R11 strobe", int'(conv_start), 1);
        step_trig(0, 1'b0);

        // R13 live write and event in one cycle
        wr(3'd4, 16'h0321);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_waddr = 3'd2; bus_wdata = 16'h0999; trig_in[0] = 1'b1;
        @(negedge clk); #1;
        bus_we = 1'b0;
        chk("R13 transfer wins", int'(smp(0)), 'h321);
        step_trig(0, 1'b0);

        wr(3'd0, 16'h019C);          // channel 1 left adjusted
        wr(3'd3, 16'hABCF);
        chk("R9 left sample", int'(smp(1)), 'hABC);
        rd(3'd3, 16'hABC0, "R9 left readback");
        rd(3'd2, 16'h0321, "R9 right readback");

        wr(3'd0, 16'h01DC);          // channel 1 falling edge
        wr(3'd5, 16'h5550);
        step_trig(1, 1'b1);
        chk("R8 rising ignored", int'(conv_start), 0);
        step_trig(1, 1'b0);
        chk("R8 falling strobe", int'(conv_start), 2);
        chk("R8 falling sample", int'(smp(1)), 'h555);

        wr(3'd1, 16'h000F);
        wr(3'd0, 16'h01DD);          // differential
        wr(3'd2, 16'h0111);
        chk("R10 paired strobe", int'(conv_start), 3);
        wr(3'd5, 16'h2220);
        step_trig(1, 1'b1);
        step_trig(1, 1'b0);
        chk("R10 partner event ignored", int'(conv_start), 0);
        chk("R10 partner sample kept", int'(smp(1)), 'h555);
        rd(3'd1, 16'h0000, "R10 partner no flags");
        wr(3'd3, 16'h7770);
        chk("R10 partner write no strobe", int'(conv_start), 0);
        chk("R10 partner write sample", int'(smp(1)), 'h777);

        wr(3'd6, 16'hFFFF);
        rd(3'd6, 16'h0000, "R1 unmapped");

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            bus_we    = ($urandom % 3) == 0;
            bus_waddr = 3'($urandom % 7);
            bus_wdata = 16'($urandom);
            trig_in   = 2'($urandom);
            bus_raddr = 3'($urandom % 8);
        end
        @(negedge clk); #1;
        bus_we = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule